// File: doc/BRIEF.md
# Dual-Tick Compensated Time Counter

This block keeps a 64-bit time count that normally advances by one on each fast reference tick. Part of the system can go into a low-power phase in which only a slow tick keeps running. The counter can keep one time base across that phase in two ways.

In hard-compensation mode, each slow tick adds the rational ratio numerator/denominator to the count. A remainder accumulator carries the fractional part, so that over time no fast-tick time is lost. In software-compensation mode, the count holds during the slow phase. The block captures a timestamp when the count leaves the fast phase and another when it returns. Software computes a correction from these and adds it through a 64-bit delta and a sync request.

Both ticks arrive as single-cycle enables in the system clock domain. Software sees the block through a simple 32-bit register port. A registered read returns data one cycle after the read strobe. A sticky interrupt status drives one interrupt line through per-bit enables.

Top module: `dualtick_timer`

## Requirements
- R1: After reset, the control word, interrupt enable and interrupt status read 0 and `irq` is low. Both load-count halves read 0xFFFFFFFF. The revision word (index 0) reads the REVISION parameter. Read data appears on `reg_rdata` in the cycle after the read strobe.
- R2: Control bit 0 enables counting and bits 2:1 select the mode. Mode 0 is normal and mode 3 behaves as normal. In normal mode the count rises by 1 on each fast tick and ignores slow ticks and `fast_active`. While bit 0 is low, the count holds.
- R3: Mode 1 is hard compensation. While `fast_active` is high, the count rises by 1 per fast tick. While it is low, fast ticks are ignored and each slow tick adds numerator/denominator (indices 3 and 4), with the remainder carried. For 0xB71B/0x40, 3 slow ticks add 2197 and 64 slow ticks add exactly 46875.
- R4: Mode 2 is software compensation. While `fast_active` is low, the count holds. The slow-tick counter (indices 9/10) rises on every slow tick while counting is enabled, in any mode.
- R5: In either compensation mode, a high-to-low change of `fast_active` captures the count as the begin stamp (indices 13/14) and sets valid bit 0 (index 17). A low-to-high change captures the end stamp (indices 15/16) and sets valid bit 1. Writing 1s to valid bits clears them.
- R6: Writing a value with bit 0 set to the sync index (18) adds the 64-bit delta (low half at index 7, high half at 8) into the count at that write's clock edge. The same edge sets status bit 2.
- R7: In hard-compensation mode only, every change of `fast_active` sets status bit 1 (switch-over done).
- R8: Status bit 0 sets while the count equals the 64-bit load value (indices 5/6). When control bit 3 is set, ticks do not advance the count past the load value.
- R9: Status (index 19) bits set whatever the enables are, and writing 1 clears a bit. `irq` is the OR of the status bits masked by the enable bits (index 2).
- R10: Reading the count low half (index 11) latches the high half. A later read of index 12 returns that latched value, even if the count has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_tick | input | 1 | Single-cycle fast reference tick enable |
| slow_tick | input | 1 | Single-cycle slow low-power tick enable |
| fast_active | input | 1 | High while the fast reference is in use |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt: OR of enabled status bits |

## Verification
Writes take effect at the clock edge that samples them. A count change from a tick or a sync request appears at that same edge, and status and `irq` follow at that edge too. The reach flag is the exception: it sets one edge after the count equals the load value. Read data is registered, so the scoreboard queues each expected word when the read strobe is driven. It compares the word at the falling edge after the sampling edge. All stimulus changes on falling edges, and `irq` is sampled a full half cycle after the write edge that changes it.

// File: rtl/dtt_pkg.sv
// Shared definitions for the dual-tick timer: mode encoding, register
// word indices and status bit positions. Assumes a word-indexed port.
package dtt_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_HARD = 2'd1,
        MODE_SOFT = 2'd2,
        MODE_ALT  = 2'd3
    } dtt_mode_e;

    localparam int IDX_W = 5;

    localparam logic [IDX_W-1:0] W_REV    = 5'd0;
    localparam logic [IDX_W-1:0] W_CTRL   = 5'd1;
    localparam logic [IDX_W-1:0] W_IEN    = 5'd2;
    localparam logic [IDX_W-1:0] W_NUM    = 5'd3;
    localparam logic [IDX_W-1:0] W_DEN    = 5'd4;
    localparam logic [IDX_W-1:0] W_LD_LO  = 5'd5;
    localparam logic [IDX_W-1:0] W_LD_HI  = 5'd6;
    localparam logic [IDX_W-1:0] W_DL_LO  = 5'd7;
    localparam logic [IDX_W-1:0] W_DL_HI  = 5'd8;
    localparam logic [IDX_W-1:0] W_SL_LO  = 5'd9;
    localparam logic [IDX_W-1:0] W_SL_HI  = 5'd10;
    localparam logic [IDX_W-1:0] W_CUR_LO = 5'd11;
    localparam logic [IDX_W-1:0] W_CUR_HI = 5'd12;
    localparam logic [IDX_W-1:0] W_BG_LO  = 5'd13;
    localparam logic [IDX_W-1:0] W_BG_HI  = 5'd14;
    localparam logic [IDX_W-1:0] W_EN_LO  = 5'd15;
    localparam logic [IDX_W-1:0] W_EN_HI  = 5'd16;
    localparam logic [IDX_W-1:0] W_VALID  = 5'd17;
    localparam logic [IDX_W-1:0] W_SYNC   = 5'd18;
    localparam logic [IDX_W-1:0] W_STAT   = 5'd19;

    localparam int ST_REACH = 0;
    localparam int ST_ADJ   = 1;
    localparam int ST_SYNC  = 2;
    localparam int ST_N     = 3;

endpackage

// File: rtl/dtt_regs.sv
// Register file and read path. Holds control, enables, ratio, load and
// delta values; decodes write strobes into pulses for the other units;
// returns registered read data with a high-half shadow for the count.
// Assumes CNT_W == 2*DATA_W and RATIO_W <= DATA_W.
module dtt_regs
    import dtt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RATIO_W  = 16,
    parameter logic [31:0] REVISION = 32'h0001_0203
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [IDX_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 ctrl_en,
    output dtt_mode_e            mode,
    output logic                 hold_at_load,
    output logic [ST_N-1:0]      ien,
    output logic [RATIO_W-1:0]   num,
    output logic [RATIO_W-1:0]   den,
    output logic [2*DATA_W-1:0]  load_val,
    output logic [2*DATA_W-1:0]  delta,
    output logic                 sync_pulse,
    output logic [1:0]           valid_clr,
    output logic [ST_N-1:0]      stat_clr,
    input  logic [2*DATA_W-1:0]  cur_count,
    input  logic [2*DATA_W-1:0]  slow_count,
    input  logic [2*DATA_W-1:0]  begin_ts,
    input  logic [2*DATA_W-1:0]  end_ts,
    input  logic [1:0]           be_valid,
    input  logic [ST_N-1:0]      status
);
    localparam int CNT_W = 2 * DATA_W;

    logic [3:0]        ctrl_q;
    logic [ST_N-1:0]   ien_q;
    logic [RATIO_W-1:0] num_q, den_q;
    logic [CNT_W-1:0]  load_q, delta_q;
    logic [DATA_W-1:0] shadow_q;
    logic              wr_stb, rd_stb;

    assign wr_stb = reg_valid && reg_write;
    assign rd_stb = reg_valid && !reg_write;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            ien_q   <= '0;
            num_q   <= '0;
            den_q   <= '0;
            load_q  <= '1;
            delta_q <= '0;
        end else if (wr_stb) begin
            case (reg_addr)
                W_CTRL:  ctrl_q <= reg_wdata[3:0];
                W_IEN:   ien_q  <= reg_wdata[ST_N-1:0];
                W_NUM:   num_q  <= reg_wdata[RATIO_W-1:0];
                W_DEN:   den_q  <= reg_wdata[RATIO_W-1:0];
                W_LD_LO: load_q[DATA_W-1:0]      <= reg_wdata;
                W_LD_HI: load_q[CNT_W-1:DATA_W]  <= reg_wdata;
                W_DL_LO: delta_q[DATA_W-1:0]     <= reg_wdata;
                W_DL_HI: delta_q[CNT_W-1:DATA_W] <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Decode single-cycle action strobes from writes.
    always_comb begin
        sync_pulse = wr_stb && (reg_addr == W_SYNC) && reg_wdata[0];
        valid_clr  = (wr_stb && reg_addr == W_VALID) ? reg_wdata[1:0] : 2'b00;
        stat_clr   = (wr_stb && reg_addr == W_STAT) ? reg_wdata[ST_N-1:0] : '0;
    end

    // Latch the count's high half whenever its low half is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (rd_stb && reg_addr == W_CUR_LO)
            shadow_q <= cur_count[CNT_W-1:DATA_W];
    end

    // Registered read data multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (rd_stb) begin
            case (reg_addr)
                W_REV:    reg_rdata <= REVISION[DATA_W-1:0];
                W_CTRL:   reg_rdata <= DATA_W'(ctrl_q);
                W_IEN:    reg_rdata <= DATA_W'(ien_q);
                W_NUM:    reg_rdata <= DATA_W'(num_q);
                W_DEN:    reg_rdata <= DATA_W'(den_q);
                W_LD_LO:  reg_rdata <= load_q[DATA_W-1:0];
                W_LD_HI:  reg_rdata <= load_q[CNT_W-1:DATA_W];
                W_DL_LO:  reg_rdata <= delta_q[DATA_W-1:0];
                W_DL_HI:  reg_rdata <= delta_q[CNT_W-1:DATA_W];
                W_SL_LO:  reg_rdata <= slow_count[DATA_W-1:0];
                W_SL_HI:  reg_rdata <= slow_count[CNT_W-1:DATA_W];
                W_CUR_LO: reg_rdata <= cur_count[DATA_W-1:0];
                W_CUR_HI: reg_rdata <= shadow_q;
                W_BG_LO:  reg_rdata <= begin_ts[DATA_W-1:0];
                W_BG_HI:  reg_rdata <= begin_ts[CNT_W-1:DATA_W];
                W_EN_LO:  reg_rdata <= end_ts[DATA_W-1:0];
                W_EN_HI:  reg_rdata <= end_ts[CNT_W-1:DATA_W];
                W_VALID:  reg_rdata <= DATA_W'(be_valid);
                W_STAT:   reg_rdata <= DATA_W'(status);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    assign ctrl_en      = ctrl_q[0];
    assign mode         = dtt_mode_e'(ctrl_q[2:1]);
    assign hold_at_load = ctrl_q[3];
    assign ien          = ien_q;
    assign num          = num_q;
    assign den          = den_q;
    assign load_val     = load_q;
    assign delta        = delta_q;

    // R10
    shadow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_addr == W_CUR_LO) |=> (shadow_q == $past(cur_count[CNT_W-1:DATA_W])));

endmodule

// File: rtl/dtt_counter.sv
// Time counter core: selects the active tick per mode and phase, applies
// the rational slow-tick increment with a remainder accumulator, adds the
// sync delta, counts slow ticks and captures phase-change timestamps.
// Assumes ticks are single-cycle enables in the clk domain.
module dtt_counter
    import dtt_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  dtt_mode_e          mode,
    input  logic               hold_at_load,
    input  logic               fast_tick,
    input  logic               slow_tick,
    input  logic               fast_active,
    input  logic [RATIO_W-1:0] num,
    input  logic [RATIO_W-1:0] den,
    input  logic [CNT_W-1:0]   load_val,
    input  logic [CNT_W-1:0]   delta,
    input  logic               sync_pulse,
    input  logic [1:0]         valid_clr,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   slow_count,
    output logic [CNT_W-1:0]   begin_ts,
    output logic [CNT_W-1:0]   end_ts,
    output logic [1:0]         be_valid,
    output logic               reach_evt,
    output logic               adj_evt,
    output logic               sync_evt
);
    localparam int SUM_W = RATIO_W + 1;

    logic [CNT_W-1:0]   count_q, slow_q, begin_q, end_q, inc;
    logic [RATIO_W-1:0] q0_q, r0_q, rem_q, rem_next, den_eff;
    logic [SUM_W-1:0]   rem_sum;
    logic [1:0]         valid_q;
    logic               fa_q, carry;
    logic               is_hard, is_soft, is_adj, use_fast, at_load;
    logic               hard_step, cap_begin, cap_end;

    assign is_hard  = (mode == MODE_HARD);
    assign is_soft  = (mode == MODE_SOFT);
    assign is_adj   = is_hard || is_soft;
    assign use_fast = !is_adj || fast_active;
    assign at_load  = hold_at_load && (count_q == load_val);
    assign den_eff  = (den == '0) ? RATIO_W'(1) : den;

    // Precompute whole and fractional parts of the ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0_q <= '0;
            r0_q <= '0;
        end else begin
            q0_q <= num / den_eff;
            r0_q <= num % den_eff;
        end
    end

    // Remainder sum and carry for one slow-tick step.
    always_comb begin
        rem_sum  = {1'b0, rem_q} + {1'b0, r0_q};
        carry    = (rem_sum >= {1'b0, den_eff});
        rem_next = carry ? RATIO_W'(rem_sum - {1'b0, den_eff}) : rem_sum[RATIO_W-1:0];
    end

    // Select this cycle's tick increment.
    always_comb begin
        hard_step = en && is_hard && !fast_active && slow_tick && !at_load;
        inc = '0;
        if (en && !at_load) begin
            if (use_fast)
                inc = fast_tick ? CNT_W'(1) : '0;
            else if (hard_step)
                inc = CNT_W'(q0_q) + CNT_W'(carry);
        end
    end

    // Main count: tick increment plus optional sync delta.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_q + inc + (sync_pulse ? delta : '0);
    end

    // Remainder accumulator, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            rem_q <= '0;
        else if (hard_step)
            rem_q <= rem_next;
    end

    // Slow-tick counter runs whenever counting is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slow_q <= '0;
        else if (en && slow_tick)
            slow_q <= slow_q + CNT_W'(1);
    end

    // Track the previous phase for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fa_q <= 1'b1;
        else
            fa_q <= fast_active;
    end

    assign cap_begin = en && is_adj && fa_q && !fast_active;
    assign cap_end   = en && is_adj && !fa_q && fast_active;

    // Timestamp capture on phase changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            begin_q <= '0;
            end_q   <= '0;
        end else begin
            if (cap_begin) begin_q <= count_q;
            if (cap_end)   end_q   <= count_q;
        end
    end

    // Capture-valid flags: set on capture, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else
            valid_q <= (valid_q & ~valid_clr) | {cap_end, cap_begin};
    end

    assign reach_evt  = en && (count_q == load_val);
    assign adj_evt    = en && is_hard && (fa_q != fast_active);
    assign sync_evt   = sync_pulse;
    assign count      = count_q;
    assign slow_count = slow_q;
    assign begin_ts   = begin_q;
    assign end_ts     = end_q;
    assign be_valid   = valid_q;

    // R2
    norm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_adj && !fast_tick && !sync_pulse) |=> $stable(count_q));

    // R3
    hard_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_step && !sync_pulse) |=>
        ((count_q - $past(count_q)) == CNT_W'($past(q0_q)) ||
         (count_q - $past(count_q)) == CNT_W'($past(q0_q)) + CNT_W'(1)));

    // R8
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_load && !sync_pulse) |=> $stable(count_q));

    // R5
    begin_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_begin |=> (valid_q[0] && begin_q == $past(count_q)));

endmodule

// File: rtl/dtt_irq.sv
// Sticky interrupt status with write-one-to-clear and an enable mask.
// Events set bits regardless of the enables; a set wins over a clear.
module dtt_irq
    import dtt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reach_evt,
    input  logic            adj_evt,
    input  logic            sync_evt,
    input  logic [ST_N-1:0] stat_clr,
    input  logic [ST_N-1:0] ien,
    output logic [ST_N-1:0] status,
    output logic            irq
);
    logic [ST_N-1:0] stat_q, evt;

    // Gather event pulses into status positions.
    always_comb begin
        evt = '0;
        evt[ST_REACH] = reach_evt;
        evt[ST_ADJ]   = adj_evt;
        evt[ST_SYNC]  = sync_evt;
    end

    // Sticky status update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~stat_clr) | evt;
    end

    assign status = stat_q;
    assign irq    = |(stat_q & ien);

    // R6
    sync_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> stat_q[ST_SYNC]);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr[ST_ADJ] && !adj_evt) |=> !stat_q[ST_ADJ]);

endmodule

// File: rtl/dualtick_timer.sv
// Top level of the dual-tick compensated time counter: ties the register
// file, the counter core and the interrupt unit together.
// Assumes both ticks and the register port share the clk domain.
module dualtick_timer
    import dtt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int RATIO_W  = 16,
    parameter logic [31:0] REVISION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              fast_active,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [4:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic               ctrl_en, hold_at_load, sync_pulse;
    dtt_mode_e          mode;
    logic [ST_N-1:0]    ien, stat_clr, status;
    logic [RATIO_W-1:0] num, den;
    logic [CNT_W-1:0]   load_val, delta, count, slow_count, begin_ts, end_ts;
    logic [1:0]         valid_clr, be_valid;
    logic               reach_evt, adj_evt, sync_evt;

    dtt_regs #(.DATA_W(DATA_W), .RATIO_W(RATIO_W), .REVISION(REVISION)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctrl_en(ctrl_en), .mode(mode), .hold_at_load(hold_at_load),
        .ien(ien), .num(num), .den(den), .load_val(load_val), .delta(delta),
        .sync_pulse(sync_pulse), .valid_clr(valid_clr), .stat_clr(stat_clr),
        .cur_count(count), .slow_count(slow_count), .begin_ts(begin_ts),
        .end_ts(end_ts), .be_valid(be_valid), .status(status)
    );

    dtt_counter #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mode(mode),
        .hold_at_load(hold_at_load), .fast_tick(fast_tick),
        .slow_tick(slow_tick), .fast_active(fast_active),
        .num(num), .den(den), .load_val(load_val), .delta(delta),
        .sync_pulse(sync_pulse), .valid_clr(valid_clr),
        .count(count), .slow_count(slow_count), .begin_ts(begin_ts),
        .end_ts(end_ts), .be_valid(be_valid), .reach_evt(reach_evt),
        .adj_evt(adj_evt), .sync_evt(sync_evt)
    );

    dtt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .reach_evt(reach_evt), .adj_evt(adj_evt),
        .sync_evt(sync_evt), .stat_clr(stat_clr), .ien(ien),
        .status(status), .irq(irq)
    );

endmodule

// File: tb/dualtick_timer_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them against registered read data one cycle later.
module dualtick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0, slow_tick = 1'b0, fast_active = 1'b1;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [4:0]  addr;
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_pend = 1'b0;

    always #5 clk = ~clk;

    dualtick_timer u_dualtick_timer (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .fast_active(fast_active), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always @(posedge clk) rd_pend <= reg_valid && !reg_write;

    // Monitor: compare each registered read against the queued expectation.
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected read data %h", reg_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (reg_rdata !== e.exp) begin
                    fails++;
                    $display("FAIL %s: index %0d got %h expected %h", e.tag, e.addr, reg_rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        @(negedge clk);
        item.addr = a; item.exp = e; item.tag = tag;
        exp_q.push_back(item);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        vectors++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic ftick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    task automatic stick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic set_fa(input logic v);
        @(negedge clk); fast_active = v;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, 32'h0001_0203, "R1 revision");
        rd(5'd5, 32'hFFFF_FFFF, "R1 load low");
        rd(5'd6, 32'hFFFF_FFFF, "R1 load high");
        rd(5'd1, 32'h0, "R1 control");
        rd(5'd19, 32'h0, "R1 status");
        chk_irq(1'b0, "R1 irq");

        // R2 normal mode: fast ticks count, slow ticks ignored
        wr(5'd1, 32'h1);
        ftick(5);
        stick(3);
        rd(5'd11, 32'd5, "R2 normal count low");
        rd(5'd12, 32'd0, "R2 normal count high");
        rd(5'd9, 32'd3, "R4 slow counter");
        // R2 mode 3 acts as normal, fast_active ignored
        wr(5'd1, 32'h7);
        set_fa(1'b0);
        ftick(2);
        rd(5'd11, 32'd7, "R2 mode3 count");
        // R2 disabled holds
        wr(5'd1, 32'h0);
        ftick(2);
        rd(5'd11, 32'd7, "R2 disabled hold");

        // R6 sync delta add, R9 status/irq
        wr(5'd7, 32'hFFFF_FFF8);
        wr(5'd8, 32'h0);
        wr(5'd18, 32'h1);
        rd(5'd19, 32'h4, "R6 sync status");
        chk_irq(1'b0, "R9 masked irq");
        wr(5'd2, 32'h4);
        chk_irq(1'b1, "R9 enabled irq");
        wr(5'd19, 32'h4);
        chk_irq(1'b0, "R9 cleared irq");
        rd(5'd19, 32'h0, "R9 status cleared");

        // R10 shadowed high half across a carry
        wr(5'd1, 32'h1);
        rd(5'd11, 32'hFFFF_FFFF, "R6 sum low");
        ftick(1);
        rd(5'd12, 32'h0, "R10 shadow high");
        rd(5'd11, 32'h0, "R10 new low");
        rd(5'd12, 32'h1, "R10 new high");

        // R3 hard compensation
        wr(5'd2, 32'h0);
        wr(5'd3, 32'h0000_B71B);
        wr(5'd4, 32'h0000_0040);
        set_fa(1'b1);
        wr(5'd1, 32'h3);
        ftick(3);
        set_fa(1'b0);
        ftick(2);
        stick(3);
        rd(5'd11, 32'd2200, "R3 three slow ticks");
        stick(61);
        rd(5'd11, 32'h0000_B71E, "R3 sixty-four slow ticks");
        rd(5'd19, 32'h2, "R7 switch-over flag");
        rd(5'd17, 32'h1, "R5 begin valid");
        rd(5'd13, 32'd3, "R5 begin low");
        rd(5'd14, 32'd1, "R5 begin high");
        set_fa(1'b1);
        rd(5'd15, 32'h0000_B71E, "R5 end low");
        rd(5'd16, 32'd1, "R5 end high");
        rd(5'd17, 32'h3, "R5 both valid");
        wr(5'd17, 32'h3);
        rd(5'd17, 32'h0, "R5 valid cleared");
        wr(5'd19, 32'h7);
        rd(5'd9, 32'd67, "R4 slow counter total");

        // R4 soft compensation: count holds in slow phase
        wr(5'd1, 32'h5);
        set_fa(1'b0);
        rd(5'd19, 32'h0, "R7 no flag in soft mode");
        rd(5'd17, 32'h1, "R5 soft begin valid");
        stick(4);
        rd(5'd11, 32'h0000_B71E, "R4 soft hold");
        rd(5'd9, 32'd71, "R4 slow counter soft");
        wr(5'd7, 32'h100);
        wr(5'd18, 32'h1);
        rd(5'd11, 32'h0000_B81E, "R6 soft delta");
        wr(5'd19, 32'h7);
        wr(5'd17, 32'h3);

        // R8 reach and hold at load
        wr(5'd6, 32'h1);
        wr(5'd5, 32'h0000_B821);
        wr(5'd1, 32'h9);
        ftick(6);
        rd(5'd11, 32'h0000_B821, "R8 held at load");
        rd(5'd19, 32'h1, "R8 reach flag");
        wr(5'd2, 32'h1);
        chk_irq(1'b1, "R8 reach irq");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d reads not returned", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule